// File: doc/BRIEF.md
# Write-Back Port Arbiter

This block stands where the results of several execution units enter the memory stage. The register file behind that stage has a single write port. So in each cycle the arbiter admits at most one result that writes a register. Each unit shows a request that carries a valid flag, a write flag, a destination tag and a data word. The arbiter picks the request from the unit with the longest latency. Every other writing request gets a stall, and its unit must hold that request unchanged until it is admitted.

Store results do not write the register file, so they do not compete for the write port. They travel on a separate store lane in the same cycle as the admitted writer. If more than one store is present, the lane takes the store from the highest-priority unit and stalls the others. Both lanes are registered. A request that the arbiter admits appears on the lane outputs one clock edge after it was presented. Because priority is fixed by unit position, a held request keeps its rank. It wins once no higher-ranked writer remains.

Top module: `wb_port_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises with no request yet admitted, `wb_valid` and `st_valid` are 0.
- R2: When at least one input has both `in_valid[i]` and `in_wr[i]` set at a clock edge, `wb_valid` is 1 after that edge. `wb_unit`, `wb_tag` and `wb_data` then carry the index, tag and data of the winning unit.
- R3: When no input has both `in_valid[i]` and `in_wr[i]` set at a clock edge, `wb_valid` is 0 after that edge.
- R4: Unit index sets the priority, and the higher index wins. With the default of four units, index 3 is the divider, 2 the multiplier, 1 the adder and 0 the integer/load path.
- R5: `stall[i]` is 1 for every input with `in_valid[i]=1` and `in_wr[i]=1` except the winning writer. At most one writing request is ever unstalled.
- R6: An input with `in_valid[i]=1` and `in_wr[i]=0` is a store. The highest-index store goes to the store lane (`st_valid`, `st_unit`, `st_tag`, `st_data`) after the edge, in the same cycle as any writer. Writers never stall a store, and the other stores are stalled.
- R7: An input with `in_valid[i]=0` never receives a stall, and its `in_wr`, tag and data have no effect on either lane.
- R8: A stalled writer that is held in place is admitted in the first cycle in which no higher-index writer is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Request present, one bit per unit |
| in_wr | input | N | Request writes the register file (0 means store) |
| in_tag | input | N*TW | Destination tag per unit, unit i at bits i*TW |
| in_data | input | N*DW | Result data per unit, unit i at bits i*DW |
| stall | output | N | Hold request, one bit per unit |
| wb_valid | output | 1 | Registered write-port lane holds a result |
| wb_unit | output | UW | Index of the admitted writer |
| wb_tag | output | TW | Tag of the admitted writer |
| wb_data | output | DW | Data of the admitted writer |
| st_valid | output | 1 | Registered store lane holds a store |
| st_unit | output | UW | Index of the admitted store |
| st_tag | output | TW | Tag of the admitted store |
| st_data | output | DW | Data of the admitted store |

## Verification
The assertions check four things on every cycle. Never more than one writer and never more than one store goes unstalled. An idle input is never stalled. The registered write lane fills exactly when a writer was present, and its unit had no higher-ranked writer on the edge before. The bench's scenarios are needed for the rest. One is the exact stall pattern for each mix of requests. Another is that tag and data are carried through correctly. A third is a held writer winning once its superior leaves. The last is that a store passes in the same cycle as a writer.

// File: rtl/wb_port_arbiter.sv
module wb_port_arbiter #(
  parameter int N  = 4,
  parameter int TW = 5,
  parameter int DW = 32,
  localparam int UW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N-1:0]    in_wr,
  input  logic [N*TW-1:0] in_tag,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    stall,
  output logic            wb_valid,
  output logic [UW-1:0]   wb_unit,
  output logic [TW-1:0]   wb_tag,
  output logic [DW-1:0]   wb_data,
  output logic            st_valid,
  output logic [UW-1:0]   st_unit,
  output logic [TW-1:0]   st_tag,
  output logic [DW-1:0]   st_data
);

  logic [N-1:0]  wr_req, st_req;
  logic          wr_hit, st_hit;
  logic [UW-1:0] wr_sel, st_sel;

  assign wr_req = in_valid & in_wr;
  assign st_req = in_valid & ~in_wr;

  always_comb begin
    wr_hit = 1'b0;
    st_hit = 1'b0;
    wr_sel = '0;
    st_sel = '0;
    for (int i = 0; i < N; i++) begin
      if (wr_req[i]) begin
        wr_hit = 1'b1;
        wr_sel = UW'(i);
      end
      if (st_req[i]) begin
        st_hit = 1'b1;
        st_sel = UW'(i);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_stall
    assign stall[g] = (wr_req[g] && wr_sel != UW'(g)) ||
                      (st_req[g] && st_sel != UW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_unit  <= '0;
      wb_tag   <= '0;
      wb_data  <= '0;
      st_valid <= 1'b0;
      st_unit  <= '0;
      st_tag   <= '0;
      st_data  <= '0;
    end else begin
      wb_valid <= wr_hit;
      st_valid <= st_hit;
      if (wr_hit) begin
        wb_unit <= wr_sel;
        wb_tag  <= in_tag[wr_sel*TW +: TW];
        wb_data <= in_data[wr_sel*DW +: DW];
      end
      if (st_hit) begin
        st_unit <= st_sel;
        st_tag  <= in_tag[st_sel*TW +: TW];
        st_data <= in_data[st_sel*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/wb_port_arbiter_checker.sv
module wb_port_arbiter_checker #(
  parameter int N  = 4,
  parameter int UW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  in_valid,
  input logic [N-1:0]  in_wr,
  input logic [N-1:0]  stall,
  input logic          wb_valid,
  input logic [UW-1:0] wb_unit
);

  AST_ONE_WRITER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_valid & in_wr & ~stall) <= 1); // R5
  AST_ONE_STORE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_valid & ~in_wr & ~stall) <= 1); // R6
  AST_IDLE_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (stall & ~in_valid) == '0); // R7
  AST_WRITER_ADMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_valid & in_wr)) |=> wb_valid); // R2
  AST_NO_WRITER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(in_valid & in_wr)) |=> !wb_valid); // R3
  AST_TOP_RANK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ((N'($past(in_valid & in_wr)) >> wb_unit) == N'(1))); // R4

endmodule

bind wb_port_arbiter wb_port_arbiter_checker #(.N(N), .UW(UW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wr(in_wr),
  .stall(stall), .wb_valid(wb_valid), .wb_unit(wb_unit)
);

// File: tb/wb_port_arbiter_test.sv
module wb_port_arbiter_test;
  localparam int N = 4, TW = 5, DW = 32, UW = 2;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 10;
  // {valid, wr, expected stall, wb_valid, wb_unit, st_valid, st_unit}
  localparam logic [17:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0},
    {4'b0001, 4'b0001, 4'b0000, 1'b1, 2'd0, 1'b0, 2'd0},
    {4'b0011, 4'b0011, 4'b0001, 1'b1, 2'd1, 1'b0, 2'd0},
    {4'b1111, 4'b1111, 4'b0111, 1'b1, 2'd3, 1'b0, 2'd0},
    {4'b0110, 4'b0110, 4'b0010, 1'b1, 2'd2, 1'b0, 2'd0},
    {4'b1101, 4'b0101, 4'b0001, 1'b1, 2'd2, 1'b1, 2'd3},
    {4'b0011, 4'b0000, 4'b0001, 1'b0, 2'd0, 1'b1, 2'd1},
    {4'b1010, 4'b1010, 4'b0010, 1'b1, 2'd3, 1'b0, 2'd0},
    {4'b0000, 4'b1111, 4'b0000, 1'b0, 2'd0, 1'b0, 2'd0},
    {4'b1001, 4'b0001, 4'b0000, 1'b1, 2'd0, 1'b1, 2'd3}
  };

  logic clk = 0, rst_n = 0;
  logic [N-1:0] in_valid = '0, in_wr = '0;
  logic [N*TW-1:0] in_tag;
  logic [N*DW-1:0] in_data;
  logic [N-1:0] stall;
  logic wb_valid, st_valid;
  logic [UW-1:0] wb_unit, st_unit;
  logic [TW-1:0] wb_tag, st_tag;
  logic [DW-1:0] wb_data, st_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_port_arbiter #(.N(N), .TW(TW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wr(in_wr),
    .in_tag(in_tag), .in_data(in_data), .stall(stall),
    .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_tag(wb_tag), .wb_data(wb_data),
    .st_valid(st_valid), .st_unit(st_unit), .st_tag(st_tag), .st_data(st_data));

  function automatic logic [TW-1:0] tag_of(int u); return TW'(u * 7 + 3); endfunction
  function automatic logic [DW-1:0] data_of(int u); return 32'hC0DE_0000 + DW'(u * 17); endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      in_tag[i*TW +: TW]  = tag_of(i);
      in_data[i*DW +: DW] = data_of(i);
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [N-1:0] v, logic [N-1:0] w);
    @(negedge clk);
    in_valid = v;
    in_wr = w;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 wb_valid in reset", 64'(wb_valid), 0);
    check("R1 st_valid in reset", 64'(st_valid), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1 wb_valid after reset", 64'(wb_valid), 0);
    check("R1 st_valid after reset", 64'(st_valid), 0);

    for (int k = 0; k < NV; k++) begin
      logic [17:0] e;
      e = VEC[k];
      drive(e[17:14], e[13:10]);
      #1;
      check($sformatf("R5 R6 R7 stall vec %0d", k), 64'(stall), 64'(e[9:6]));
      @(negedge clk);
      check($sformatf("R2 R3 wb_valid vec %0d", k), 64'(wb_valid), 64'(e[5]));
      if (e[5]) begin
        check($sformatf("R4 wb_unit vec %0d", k), 64'(wb_unit), 64'(e[4:3]));
        check($sformatf("R2 wb_tag vec %0d", k), 64'(wb_tag), 64'(tag_of(int'(e[4:3]))));
        check($sformatf("R2 wb_data vec %0d", k), 64'(wb_data), 64'(data_of(int'(e[4:3]))));
      end
      check($sformatf("R6 st_valid vec %0d", k), 64'(st_valid), 64'(e[2]));
      if (e[2]) begin
        check($sformatf("R6 st_unit vec %0d", k), 64'(st_unit), 64'(e[1:0]));
        check($sformatf("R6 st_data vec %0d", k), 64'(st_data), 64'(data_of(int'(e[1:0]))));
      end
    end

    // R8: adder held behind divider, wins when divider leaves
    drive(4'b1010, 4'b1010);
    #1 check("R8 adder stalled", 64'(stall), 64'b0010);
    drive(4'b0010, 4'b0010);
    check("R8 divider first", 64'(wb_unit), 3);
    #1 check("R8 held adder free", 64'(stall), 0);
    @(negedge clk);
    check("R8 held adder admitted valid", 64'(wb_valid), 1);
    check("R8 held adder admitted unit", 64'(wb_unit), 1);

    // R7: idle inputs with data changes leave lanes empty
    drive(4'b0000, 4'b1010);
    in_tag[0 +: TW] = 5'h1F;
    @(negedge clk);
    check("R7 idle wb_valid", 64'(wb_valid), 0);
    check("R7 idle st_valid", 64'(st_valid), 0);
    in_tag[0 +: TW] = tag_of(0);

    // R1: reset mid-traffic clears lanes
    drive(4'b1111, 4'b0111);
    rst_n = 0;
    @(negedge clk);
    check("R1 mid reset wb_valid", 64'(wb_valid), 0);
    check("R1 mid reset st_valid", 64'(st_valid), 0);
    in_valid = '0;
    rst_n = 1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule